// File: doc/BRIEF.md
# Degree-3 Variable Node Unit for a Rebalanced Belief-Propagation Decoder

This unit performs the variable-node half of one decoding iteration for a variable node with exactly three check-node edges. The decoder it belongs to moves the nonlinear magnitude transform out of the check phase and into the variable phase. The check phase is therefore left with sums and sign products, and each phase holds about one lookup and one addition of logic.

On every cycle where the input strobe is high, the unit accepts three check-to-variable soft messages and one pre-scaled channel intrinsic value. Each message first passes through a sign-aware magnitude lookup. For each edge, the unit then adds the transformed terms of the two other edges and subtracts the intrinsic value. The result goes out as that edge's variable-to-check message, clipped to message width. The unit also produces a hard-decision bit taken from the total over all three edges.

The datapath is split into three register stages with about one adder per stage. It takes a new set of inputs on every cycle and never stalls. Address generation, message storage, the check-node unit and stopping rules all sit outside this unit.

Top module: `ldpc_vnode_unit`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `valid_o`, `hard_o` and every slice of `v2c_o` are 0.
- R2: A set of inputs presented with `valid_i` high appears on the outputs, with `valid_o` high, exactly three rising clock edges later. A new set can be accepted on every cycle.
- R3: Each incoming message r (6-bit two's complement) is mapped to a transformed term. The magnitude part f(|r|) is: 20 for |r| ≤ 1, 12 for |r| = 2, 8 for |r| = 3, 5 for |r| in 4..5, 3 for |r| in 6..7, 2 for |r| in 8..10, 1 for |r| in 11..15, and 0 for |r| ≥ 16. The term carries the sign of r, with r = 0 counted as positive.
- R4: The outgoing message on edge k equals the sum of the transformed terms of the other two edges, minus the intrinsic value.
- R5: The outgoing messages saturate to the range −32..+31 instead of wrapping.
- R6: `hard_o` is 1 when (sum of all three transformed terms) minus the intrinsic value is negative, and 0 otherwise.
- R7: Cycles with `valid_i` low do not change `v2c_o` or `hard_o`. They produce `valid_o` low three edges later.
- R8: An intrinsic value of −32 is subtracted exactly, contributing +32 without wrapping before the saturation of R5.
- R9: Edge k uses bits [6k+5:6k] of both `c2v_i` and `v2c_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set is present this cycle |
| c2v_i | input | 18 | Three check-to-variable messages, edge k in bits [6k+5:6k] |
| intr_i | input | 6 | Scaled channel intrinsic value, two's complement |
| valid_o | output | 1 | Output set is present this cycle |
| v2c_o | output | 18 | Three variable-to-check messages, edge k in bits [6k+5:6k] |
| hard_o | output | 1 | Hard decision: 1 means negative log-likelihood |

## Verification
The stimulus places each lookup magnitude band on a single edge, with the other edges forced to a zero term. A wrong table entry or a lost sign then shows up directly as a wrong outgoing value on the neighbouring edges, three edges after the input. A stage whose data register loads without a strobe, or whose valid bit drops out, breaks the held-value or latency checks on the very next idle or busy cycle. Overflow faults in the 8-bit sums only become visible with large same-signed inputs and an intrinsic of −32, so directed cases drive exactly those extremes.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  localparam int unsigned MSG_W = 6;
  localparam int unsigned SUM_W = 8;
  localparam int unsigned DEG   = 3;

  typedef logic signed [MSG_W-1:0] msg_t;
  typedef logic signed [SUM_W-1:0] sum_t;

  localparam sum_t SAT_HI = sum_t'((1 << (MSG_W - 1)) - 1);
  localparam sum_t SAT_LO = -SAT_HI - sum_t'(1);

  // sign-aware magnitude transform, two's-complement result
  function automatic sum_t psi_term(input msg_t r);
    logic [MSG_W-1:0] mag;
    sum_t             f;
    mag = r[MSG_W-1] ? MSG_W'(-r) : MSG_W'(r);
    if      (mag <= MSG_W'(1))  f = sum_t'(20);
    else if (mag <= MSG_W'(2))  f = sum_t'(12);
    else if (mag <= MSG_W'(3))  f = sum_t'(8);
    else if (mag <= MSG_W'(5))  f = sum_t'(5);
    else if (mag <= MSG_W'(7))  f = sum_t'(3);
    else if (mag <= MSG_W'(10)) f = sum_t'(2);
    else if (mag <= MSG_W'(15)) f = sum_t'(1);
    else                        f = sum_t'(0);
    return r[MSG_W-1] ? -f : f;
  endfunction

  function automatic msg_t sat_msg(input sum_t s);
    if (s > SAT_HI) return msg_t'(SAT_HI[MSG_W-1:0]);
    if (s < SAT_LO) return msg_t'(SAT_LO[MSG_W-1:0]);
    return msg_t'(s[MSG_W-1:0]);
  endfunction
endpackage

// File: rtl/vnu_psi_stage.sv
module vnu_psi_stage
  import vnu_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [DEG*MSG_W-1:0]   c2v_i,
  input  msg_t                   intr_i,
  output logic                   valid_o,
  output sum_t                   term_o [DEG],
  output sum_t                   nint_o
);
  logic valid_q;
  sum_t term_q [DEG];
  sum_t nint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      nint_q  <= '0;
      for (int k = 0; k < DEG; k++) term_q[k] <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        nint_q <= -sum_t'(intr_i);
        for (int k = 0; k < DEG; k++)
          term_q[k] <= psi_term(msg_t'(c2v_i[k*MSG_W +: MSG_W]));
      end
    end
  end

  assign valid_o = valid_q;
  assign nint_o  = nint_q;

  for (genvar k = 0; k < DEG; k++) begin : g_term
    assign term_o[k] = term_q[k];

    // R3: a nonzero term keeps the sign of the message it came from
    a_r3_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && term_q[k] != '0) |->
        (term_q[k][SUM_W-1] == $past(c2v_i[k*MSG_W + MSG_W - 1])));
  end
endmodule

// File: rtl/vnu_sum_stage.sv
module vnu_sum_stage
  import vnu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  sum_t term_i [DEG],
  input  sum_t nint_i,
  output logic valid_o,
  output sum_t excl_o [DEG],
  output sum_t tail_o,
  output sum_t nint_o
);
  logic valid_q;
  sum_t excl_d [DEG];
  sum_t excl_q [DEG];
  sum_t tail_q;
  sum_t nint_q;

  // per-edge sum over all other edges
  always_comb begin
    for (int k = 0; k < DEG; k++) begin
      excl_d[k] = '0;
      for (int j = 0; j < DEG; j++)
        if (j != k) excl_d[k] = excl_d[k] + term_i[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tail_q  <= '0;
      nint_q  <= '0;
      for (int k = 0; k < DEG; k++) excl_q[k] <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        tail_q <= term_i[DEG-1] + nint_i;
        nint_q <= nint_i;
        for (int k = 0; k < DEG; k++) excl_q[k] <= excl_d[k];
      end
    end
  end

  assign valid_o = valid_q;
  assign tail_o  = tail_q;
  assign nint_o  = nint_q;
  for (genvar k = 0; k < DEG; k++) begin : g_out
    assign excl_o[k] = excl_q[k];
  end

  // R2: strobe advances one stage per edge
  a_r2_valid_step_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q == $past(valid_i));
endmodule

// File: rtl/vnu_out_stage.sv
module vnu_out_stage
  import vnu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  sum_t                 excl_i [DEG],
  input  sum_t                 tail_i,
  input  sum_t                 nint_i,
  output logic                 valid_o,
  output logic [DEG*MSG_W-1:0] v2c_o,
  output logic                 hard_o
);
  logic valid_q;
  msg_t v2c_q [DEG];
  logic hard_q;
  sum_t total;

  // total over all edges: (all but last) + (last + negated intrinsic)
  assign total = excl_i[DEG-1] + tail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hard_q  <= 1'b0;
      for (int k = 0; k < DEG; k++) v2c_q[k] <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        hard_q <= total[SUM_W-1];
        for (int k = 0; k < DEG; k++) v2c_q[k] <= sat_msg(excl_i[k] + nint_i);
      end
    end
  end

  assign valid_o = valid_q;
  assign hard_o  = hard_q;
  for (genvar k = 0; k < DEG; k++) begin : g_pack
    assign v2c_o[k*MSG_W +: MSG_W] = v2c_q[k];
  end

  // R2: strobe advances one stage per edge
  a_r2_valid_step_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q == $past(valid_i));

  // R7: idle slots leave the results untouched
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(v2c_o) && $stable(hard_o)));
endmodule

// File: rtl/ldpc_vnode_unit.sv
module ldpc_vnode_unit
  import vnu_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [DEG*MSG_W-1:0]        c2v_i,
  input  logic signed [MSG_W-1:0]     intr_i,
  output logic                        valid_o,
  output logic [DEG*MSG_W-1:0]        v2c_o,
  output logic                        hard_o
);
  logic s1_valid;
  sum_t s1_term [DEG];
  sum_t s1_nint;
  logic s2_valid;
  sum_t s2_excl [DEG];
  sum_t s2_tail;
  sum_t s2_nint;

  vnu_psi_stage i_psi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .c2v_i   (c2v_i),
    .intr_i  (intr_i),
    .valid_o (s1_valid),
    .term_o  (s1_term),
    .nint_o  (s1_nint)
  );

  vnu_sum_stage i_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .term_i  (s1_term),
    .nint_i  (s1_nint),
    .valid_o (s2_valid),
    .excl_o  (s2_excl),
    .tail_o  (s2_tail),
    .nint_o  (s2_nint)
  );

  vnu_out_stage i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s2_valid),
    .excl_i  (s2_excl),
    .tail_i  (s2_tail),
    .nint_i  (s2_nint),
    .valid_o (valid_o),
    .v2c_o   (v2c_o),
    .hard_o  (hard_o)
  );
endmodule

// File: tb/test_ldpc_vnode_unit.sv
module test_ldpc_vnode_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [17:0] c2v_i = '0;
  logic signed [5:0] intr_i = '0;
  logic        valid_o;
  logic [17:0] v2c_o;
  logic        hard_o;

  ldpc_vnode_unit i_ldpc_vnode_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .c2v_i(c2v_i),
    .intr_i(intr_i), .valid_o(valid_o), .v2c_o(v2c_o), .hard_o(hard_o)
  );

  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  int    hv [4];
  int    hc [4][3];
  int    hi [4];
  string ht [4];
  int    held_o [3];
  int    held_h = 0;

  function automatic int bmag(int m);
    if (m <= 1)  return 20;
    if (m == 2)  return 12;
    if (m == 3)  return 8;
    if (m <= 5)  return 5;
    if (m <= 7)  return 3;
    if (m <= 10) return 2;
    if (m <= 15) return 1;
    return 0;
  endfunction

  function automatic int bterm(int r);
    return (r < 0) ? -bmag(-r) : bmag(r);
  endfunction

  function automatic int bsat(int s);
    if (s > 31)  return 31;
    if (s < -32) return -32;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int c0, int c1, int c2, int ir, string tag);
    int slot, ev, t[3], raw;
    string dtag;
    @(negedge clk);
    ev = 0;
    slot = (cyc + 1) % 4;  // entry driven three steps ago
    if (cyc >= 3 && hv[slot] != 0) begin
      ev = 1;
      for (int k = 0; k < 3; k++) t[k] = bterm(hc[slot][k]);
      for (int k = 0; k < 3; k++)
        held_o[k] = bsat(t[0] + t[1] + t[2] - t[k] - hi[slot]);
      held_h = ((t[0] + t[1] + t[2] - hi[slot]) < 0) ? 1 : 0;
    end
    chk("R2 valid_o", int'(valid_o), ev);
    for (int k = 0; k < 3; k++)  // R9 slice placement
      chk(ev ? ht[slot] : "R7 held v2c", int'($signed(v2c_o[k*6 +: 6])), held_o[k]);
    chk(ev ? "R6 hard" : "R7 held hard", int'(hard_o), held_h);
    // drive next set
    dtag = tag;
    if (dtag == "") begin
      dtag = (ir == -32) ? "R8 v2c" : "R4 v2c";
      for (int k = 0; k < 3; k++) begin
        raw = bterm(c0) + bterm(c1) + bterm(c2) - bterm(k == 0 ? c0 : (k == 1 ? c1 : c2)) - ir;
        if (raw > 31 || raw < -32) dtag = "R5 v2c";
      end
    end
    valid_i = v;
    c2v_i   = {6'(c2), 6'(c1), 6'(c0)};
    intr_i  = 6'(ir);
    hv[cyc % 4] = v ? 1 : 0;
    hc[cyc % 4][0] = c0; hc[cyc % 4][1] = c1; hc[cyc % 4][2] = c2;
    hi[cyc % 4] = ir;
    ht[cyc % 4] = dtag;
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5c_77a3));
    for (int i = 0; i < 4; i++) hv[i] = 0;
    for (int k = 0; k < 3; k++) held_o[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid_o in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid_o", int'(valid_o), 0);
    chk("R1 v2c_o", int'(v2c_o), 0);
    chk("R1 hard_o", int'(hard_o), 0);

    // R3: each lookup band seen alone on edges 1 and 2
    for (int x = -32; x < 32; x++) step(1'b1, x, -32, -32, 0, "R3 lookup");
    // R5: positive and negative saturation; R8: intrinsic -32
    step(1'b1, 0, 0, 0, -32, "");
    step(1'b1, -1, -1, -1, 31, "");
    step(1'b1, -32, -32, -32, -32, "");
    step(1'b1, 1, -1, 2, -32, "");
    // R6: total exactly zero counts as non-negative
    step(1'b1, 3, -32, -32, 8, "");
    step(1'b1, 3, -32, -32, 9, "");
    // R7: idle gaps in the stream
    step(1'b0, 5, 5, 5, 5, "");
    step(1'b0, -9, 4, 0, -3, "");
    step(1'b1, 2, -2, 9, 4, "");
    step(1'b0, 0, 0, 0, 0, "");
    // R2, R4: random stream with random idle slots
    for (int i = 0; i < 3000; i++) begin
      bit v;
      int a, b, c, d;
      v = ($urandom_range(3) != 0);
      a = int'($urandom_range(63)) - 32;
      b = int'($urandom_range(63)) - 32;
      c = int'($urandom_range(63)) - 32;
      d = int'($urandom_range(63)) - 32;
      step(v, a, b, c, d, "");
    end
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, "");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule